// File: doc/BRIEF.md
# Multi-Threshold Trigger Primitive Encoder

This block turns a bank of digitized detector channels into a compact trigger primitive once per beam crossing. Samples for all channels arrive together on one wide bus at six times the crossing rate, each beat qualified by a valid flag. A crossing strobe closes the current window. For every channel the block takes the largest sample seen in that window and removes a programmable per-channel offset, clamping at zero. It then counts how many of that channel's seven programmable levels the result rises above. The count is a 3-bit code, and all channels' codes are packed into one primitive word that is presented with a one-clock valid pulse.

Levels and offsets are loaded through a simple write port that addresses one channel and one slot per cycle. Writes go into a staging copy and are moved into the active copy only at a crossing boundary, so a window is never judged against a mix of old and new settings. A downstream trigger stage consumes the primitive word. It may use the codes as thermometer levels when the levels are loaded in ascending order.

Top module: `tpe_top`

## Requirements
- R1: After reset `prim_valid` is 0 and `prim_word` is all zeros. Every level resets to 4095 and every offset resets to 0, so a crossing evaluated before any write yields code 0 on every channel.
- R2: `prim_valid` is high for exactly the one clock cycle that follows each cycle in which `xing_strobe` is high, and it is low at all other times. Back-to-back strobes give back-to-back pulses.
- R3: A channel's code equals the number of its seven levels that its corrected window maximum strictly exceeds. This holds whatever order the levels are loaded in.
- R4: The window maximum covers the samples with `smp_valid` high from the cycle after the previous strobe up to and including the strobe cycle itself. Samples with `smp_valid` low have no effect.
- R5: The corrected value is the window maximum minus the channel's offset, or 0 when the offset is not smaller than the maximum.
- R6: A write lands in the staging copy. It becomes active at the first strobe strictly after the write cycle, and it first affects the window that opens at that strobe. A write in the same cycle as a strobe therefore does not touch the crossing closing there, nor the next one.
- R7: Channel i's sample occupies `smp_data[12i+11:12i]` and its code occupies `prim_word[3i+2:3i]`.
- R8: `cfg_sel` values 0 to 6 select level 0 to 6, and value 7 selects the offset. A write with `cfg_ch` of 48 or above changes nothing.
- R9: A window with no valid sample has a maximum of 0. After each strobe the running maximum restarts from 0.
- R10: `prim_word` holds its value in every cycle in which `prim_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Qualifies the current sample beat |
| smp_data | input | 576 | One 12-bit sample per channel |
| xing_strobe | input | 1 | Closes the crossing window in this cycle |
| cfg_we | input | 1 | Write enable for the settings port |
| cfg_ch | input | 6 | Channel addressed by the write |
| cfg_sel | input | 3 | Slot: 0 to 6 are levels, 7 is the offset |
| cfg_data | input | 12 | Value written |
| prim_valid | output | 1 | One-cycle pulse marking a new primitive word |
| prim_word | output | 144 | Packed 3-bit codes, one per channel |

## Verification
Two kinds of coincidence are provoked. In the first, a sample beat arrives in the very cycle that `xing_strobe` closes the window. The bench models that beat as part of the closing window, so a design that dropped it or pushed it into the next window would give a different code. In the second, a settings write arrives in the strobe cycle. The scoreboard's model moves staging to active before it applies the write, so the write must show up only two crossings later. Back-to-back strobes, and windows whose every beat is invalid, are also scored word by word.

// File: rtl/tpe_pkg.sv
package tpe_pkg;
  localparam int DEF_NUM_CH  = 48;
  localparam int DEF_SMP_W   = 12;
  localparam int DEF_NUM_THR = 7;
endpackage

// File: rtl/tpe_cfg_bank.sv
module tpe_cfg_bank #(
  parameter int NUM_CH  = tpe_pkg::DEF_NUM_CH,
  parameter int SMP_W   = tpe_pkg::DEF_SMP_W,
  parameter int NUM_THR = tpe_pkg::DEF_NUM_THR,
  localparam int CH_AW  = $clog2(NUM_CH),
  localparam int SEL_W  = $clog2(NUM_THR + 1),
  localparam int SLOTS  = NUM_THR + 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [CH_AW-1:0]                  cfg_ch,
  input  logic [SEL_W-1:0]                  cfg_sel,
  input  logic [SMP_W-1:0]                  cfg_data,
  input  logic                              boundary,
  output logic [NUM_CH*NUM_THR*SMP_W-1:0]   act_thr,
  output logic [NUM_CH*SMP_W-1:0]           act_ped
);
  // Slot NUM_THR of each channel is the offset; the others are levels.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam logic [SMP_W-1:0] INIT = (s == NUM_THR) ? '0 : '1;
      logic [SMP_W-1:0] stage_q, live_q;
      logic             hit;
      assign hit = cfg_we && (cfg_ch == CH_AW'(c)) && (cfg_sel == SEL_W'(s));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage_q <= INIT;
          live_q  <= INIT;
        end else begin
          if (hit)      stage_q <= cfg_data;
          if (boundary) live_q  <= stage_q;
        end
      end

      if (s == NUM_THR) begin : g_ped
        assign act_ped[c*SMP_W +: SMP_W] = live_q;
      end else begin : g_thr
        assign act_thr[(c*NUM_THR + s)*SMP_W +: SMP_W] = live_q;
      end
    end
  end
endmodule

// File: rtl/tpe_chan.sv
module tpe_chan #(
  parameter int SMP_W   = tpe_pkg::DEF_SMP_W,
  parameter int NUM_THR = tpe_pkg::DEF_NUM_THR,
  localparam int CODE_W = $clog2(NUM_THR + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_valid,
  input  logic [SMP_W-1:0]           sample,
  input  logic                       boundary,
  input  logic [NUM_THR*SMP_W-1:0]   thr,
  input  logic [SMP_W-1:0]           ped,
  output logic [SMP_W-1:0]           run_max,
  output logic [CODE_W-1:0]          code
);
  function automatic logic [SMP_W-1:0] sat_sub(input logic [SMP_W-1:0] a,
                                               input logic [SMP_W-1:0] b);
    return (a > b) ? (a - b) : '0;
  endfunction

  function automatic logic [CODE_W-1:0] level_count(input logic [SMP_W-1:0] v,
                                                    input logic [NUM_THR*SMP_W-1:0] lv);
    logic [CODE_W-1:0] n;
    n = '0;
    for (int k = 0; k < NUM_THR; k++)
      n = n + CODE_W'(v > lv[k*SMP_W +: SMP_W]);
    return n;
  endfunction

  logic [SMP_W-1:0] run_q;
  logic [SMP_W-1:0] win_max;
  logic             take;

  assign take    = smp_valid && (sample > run_q);
  assign win_max = take ? sample : run_q;
  assign run_max = run_q;
  assign code    = level_count(sat_sub(win_max, ped), thr);

  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= '0;
    else if (boundary) run_q <= '0;
    else if (take)     run_q <= sample;
  end
endmodule

// File: rtl/tpe_top.sv
module tpe_top #(
  parameter int NUM_CH  = tpe_pkg::DEF_NUM_CH,
  parameter int SMP_W   = tpe_pkg::DEF_SMP_W,
  parameter int NUM_THR = tpe_pkg::DEF_NUM_THR,
  localparam int CH_AW  = $clog2(NUM_CH),
  localparam int SEL_W  = $clog2(NUM_THR + 1),
  localparam int CODE_W = $clog2(NUM_THR + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_valid,
  input  logic [NUM_CH*SMP_W-1:0]    smp_data,
  input  logic                       xing_strobe,
  input  logic                       cfg_we,
  input  logic [CH_AW-1:0]           cfg_ch,
  input  logic [SEL_W-1:0]           cfg_sel,
  input  logic [SMP_W-1:0]           cfg_data,
  output logic                       prim_valid,
  output logic [NUM_CH*CODE_W-1:0]   prim_word
);
  logic [NUM_CH*NUM_THR*SMP_W-1:0] act_thr;
  logic [NUM_CH*SMP_W-1:0]         act_ped;
  logic [NUM_CH*SMP_W-1:0]         run_max_flat;
  logic [NUM_CH*CODE_W-1:0]        code_flat;
  logic [NUM_CH*(NUM_THR+1)*SMP_W-1:0] act_cfg;
  logic                            win_close;

  assign win_close = xing_strobe;
  assign act_cfg   = {act_thr, act_ped};

  tpe_cfg_bank #(.NUM_CH(NUM_CH), .SMP_W(SMP_W), .NUM_THR(NUM_THR)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .boundary(win_close),
    .act_thr(act_thr), .act_ped(act_ped)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    tpe_chan #(.SMP_W(SMP_W), .NUM_THR(NUM_THR)) u_chan (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .sample(smp_data[c*SMP_W +: SMP_W]), .boundary(win_close),
      .thr(act_thr[c*NUM_THR*SMP_W +: NUM_THR*SMP_W]),
      .ped(act_ped[c*SMP_W +: SMP_W]),
      .run_max(run_max_flat[c*SMP_W +: SMP_W]),
      .code(code_flat[c*CODE_W +: CODE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prim_valid <= 1'b0;
      prim_word  <= '0;
    end else begin
      prim_valid <= win_close;
      if (win_close) prim_word <= code_flat;
    end
  end
endmodule

// File: rtl/tpe_checker.sv
module tpe_checker #(
  parameter int WORD_W = 144,
  parameter int CFG_W  = 4608,
  parameter int RUN_W  = 576
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xing_strobe,
  input logic              prim_valid,
  input logic [WORD_W-1:0] prim_word,
  input logic [CFG_W-1:0]  act_cfg,
  input logic [RUN_W-1:0]  run_max_flat
);
  AST_VALID_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    xing_strobe |=> prim_valid);                                   // R2
  AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid |-> $past(xing_strobe));                            // R2
  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !prim_valid |-> $stable(prim_word));                           // R10
  AST_CFG_SWAP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !xing_strobe |=> $stable(act_cfg));                            // R6
  AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    xing_strobe |=> (run_max_flat == '0));                         // R9
endmodule

bind tpe_top tpe_checker #(
  .WORD_W(NUM_CH*CODE_W), .CFG_W(NUM_CH*(NUM_THR+1)*SMP_W), .RUN_W(NUM_CH*SMP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .xing_strobe(xing_strobe), .prim_valid(prim_valid),
  .prim_word(prim_word), .act_cfg(act_cfg), .run_max_flat(run_max_flat)
);

// File: tb/tb_tpe_top.sv
module tb_tpe_top;
  localparam int NCH = 48;
  localparam int SW  = 12;
  localparam int NT  = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_valid = 1'b0;
  logic [NCH*SW-1:0] smp_data = '0;
  logic              xing_strobe = 1'b0;
  logic              cfg_we = 1'b0;
  logic [5:0]        cfg_ch = '0;
  logic [2:0]        cfg_sel = '0;
  logic [SW-1:0]     cfg_data = '0;
  logic              prim_valid;
  logic [NCH*3-1:0]  prim_word;

  always #4 clk = ~clk;

  tpe_top dut (.*);

  int n_tests = 0, n_fail = 0;
  int thr_sh[NCH][NT], thr_act[NCH][NT];
  int ped_sh[NCH], ped_act[NCH], runm[NCH];
  logic [NCH*3-1:0] exp_q[$];
  string            tag_q[$];
  bit               mon_on = 0;

  function automatic int smp(int c, int n, int seed);
    return (c*53 + n*197 + seed*911) % 1200;
  endfunction

  function automatic logic [NCH*3-1:0] model_word(bit v, logic [NCH*SW-1:0] d);
    logic [NCH*3-1:0] w;
    for (int c = 0; c < NCH; c++) begin
      int m, corr, cnt;
      m = runm[c];
      if (v && int'(d[c*SW +: SW]) > m) m = int'(d[c*SW +: SW]);
      corr = (m > ped_act[c]) ? m - ped_act[c] : 0;
      cnt = 0;
      for (int k = 0; k < NT; k++) if (corr > thr_act[c][k]) cnt++;
      w[c*3 +: 3] = 3'(cnt);
    end
    return w;
  endfunction

  // Driver: one cycle of stimulus plus the reference model update.
  task automatic step(bit v, logic [NCH*SW-1:0] d, bit s, bit we,
                      int ch, int sel, int val, string tag);
    @(negedge clk);
    smp_valid = v; smp_data = d; xing_strobe = s;
    cfg_we = we; cfg_ch = 6'(ch); cfg_sel = 3'(sel); cfg_data = 12'(val);
    if (s) begin
      exp_q.push_back(model_word(v, d));
      tag_q.push_back(tag);
      for (int c = 0; c < NCH; c++) begin
        ped_act[c] = ped_sh[c];
        for (int k = 0; k < NT; k++) thr_act[c][k] = thr_sh[c][k];
        runm[c] = 0;
      end
    end else if (v) begin
      for (int c = 0; c < NCH; c++)
        if (int'(d[c*SW +: SW]) > runm[c]) runm[c] = int'(d[c*SW +: SW]);
    end
    if (we && ch < NCH) begin
      if (sel == NT) ped_sh[ch] = val; else thr_sh[ch][sel] = val;
    end
  endtask

  task automatic cfg(int ch, int sel, int val);
    step(0, '0, 0, 1, ch, sel, val, "");
  endtask

  function automatic logic [NCH*SW-1:0] beat(int n, int seed);
    logic [NCH*SW-1:0] d;
    for (int c = 0; c < NCH; c++) d[c*SW +: SW] = 12'(smp(c, n, seed));
    return d;
  endfunction

  // Six beats; the last one carries the strobe. Invalid beats carry all ones.
  task automatic window(int seed, bit [5:0] vmask, string tag);
    for (int n = 0; n < 6; n++)
      step(vmask[n], vmask[n] ? beat(n, seed) : '1, n == 5, 0, 0, 0, 0, tag);
  endtask

  task automatic check(bit ok, string req, string what, logic [NCH*3-1:0] act,
                       logic [NCH*3-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor: samples 2 ns after each rising edge.
  initial begin
    logic [NCH*3-1:0] last;
    last = '0;
    forever begin
      @(posedge clk); #2;
      if (mon_on) begin
        if (prim_valid) begin
          if (exp_q.size() == 0) begin
            check(0, "R2", "unexpected pulse", prim_word, '0);
          end else begin
            logic [NCH*3-1:0] e;
            string t;
            e = exp_q.pop_front(); t = tag_q.pop_front();
            check(prim_word === e, t, "primitive word", prim_word, e);
          end
        end else begin
          check(prim_word === last, "R10", "word held", prim_word, last);
        end
        last = prim_word;
      end
    end
  end

  initial begin
    #(8*200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      ped_sh[c] = 0; ped_act[c] = 0; runm[c] = 0;
      for (int k = 0; k < NT; k++) begin thr_sh[c][k] = 4095; thr_act[c][k] = 4095; end
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(prim_valid === 1'b0 && prim_word === '0, "R1", "reset state",
          {143'd0, prim_valid} | prim_word, '0);
    mon_on = 1;

    window(1, 6'h3F, "R1");                       // defaults give code 0
    // R3 ascending levels, distinct per channel
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < NT; k++) cfg(c, k, 100*(k+1) + c);
    window(2, 6'h3F, "R6");                       // still old settings
    window(3, 6'h3F, "R3");
    window(4, 6'h3F, "R7");
    window(5, 6'h3F, "R3");
    window(6, 6'b010101, "R4");                   // invalid beats all ones
    window(7, 6'b100000, "R4");                   // only the strobe beat
    // R5 offsets, large ones saturate
    for (int c = 0; c < NCH; c++) cfg(c, NT, 300 + 10*c);
    window(8, 6'h3F, "R6");
    window(9, 6'h3F, "R5");
    window(10, 6'b000011, "R5");
    // R3 unordered levels on a few channels
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < NT; k++) cfg(c, k, 700 - 90*k);
    window(11, 6'h3F, "R6");
    window(12, 6'h3F, "R3");
    // R8 writes to channels beyond the bank
    for (int c = NCH; c < 64; c++)
      for (int k = 0; k <= NT; k++) cfg(c, k, 0);
    window(13, 6'h3F, "R8");
    window(14, 6'h3F, "R8");
    // R6 write coinciding with the strobe
    for (int n = 0; n < 5; n++) step(1, beat(n, 15), 0, 0, 0, 0, 0, "R6");
    step(1, beat(5, 15), 1, 1, 5, 0, 0, "R6");
    window(16, 6'h3F, "R6");
    window(17, 6'h3F, "R6");
    // R9 empty window with zero levels and offset on channel 10
    for (int k = 0; k <= NT; k++) cfg(10, k, 0);
    window(18, 6'h3F, "R9");
    window(19, 6'h00, "R9");
    window(20, 6'h3F, "R9");
    // R2 back-to-back strobes
    for (int n = 0; n < 3; n++) step(1, beat(n, 21), 1, 0, 0, 0, 0, "R2");
    step(0, '0, 0, 0, 0, 0, 0, "");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2", "missing pulses", 144'(exp_q.size()), '0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule